// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves like a byte-addressed serial EEPROM on a two-wire bus. It runs on a fast system clock, samples the bus clock and data lines through synchronizers, and drives the data line only through an open-drain enable. Three strap inputs set its bus address, so up to eight copies can share one bus. A write-protect input blocks every change to the stored data.

A master writes by sending the device byte, a two-byte word address and one or more data bytes. The data bytes are collected in a page buffer and copied into the storage array when the stop condition arrives. After that copy the block stays silent for a fixed number of system clocks, so a master can poll until the write has finished. Reads start either at the internal address counter or at an address loaded by a write header without data. They continue byte by byte for as long as the master acknowledges.

Top module: `serial_eeprom_slave`

## Requirements
- R1: The device byte carries the pattern 1010 in bits 7 to 4, the strap inputs in bits 3 to 1 (strap bit 2 in bit 3), and the direction in bit 0, where 1 selects a read.
- R2: On a matching device byte the slave pulls SDA low for the ninth clock. On a mismatch it gives no acknowledge and ignores all bus traffic until the next start, including bytes that would otherwise match.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Incoming bits are taken on SCL rising. The slave changes its SDA drive only while SCL is low, and it drives nothing after reset.
- R4: A write sends the high address byte, then the low address byte, then data bytes. The slave acknowledges every one of these, for any number of data bytes, including more than a full page.
- R5: During a write only the low 7 address bits advance. A write that runs past the end of a 128-byte page wraps to the start of that same page and overwrites earlier bytes, and bytes outside the page are left unchanged.
- R6: A stop after at least one data byte commits the page and starts a busy period of BUSY_CYCLES system clocks. During that period the device byte is not acknowledged. After it, the device byte is acknowledged again.
- R7: While wp_i is high, data bytes are still acknowledged, but the array keeps its old contents and no busy period starts.
- R8: The address counter holds the last address accessed, plus one. A read that sends no address returns the byte at the counter.
- R9: A write header carrying only the address, followed by a repeated start and a read device byte, returns the byte at that address.
- R10: Each master acknowledge during a read fetches the next byte. The read wraps from the last array location to address 0. A master NACK followed by a stop ends the read.
- R11: A stop after only the address bytes commits nothing and starts no busy period. A start arriving in any state, including inside a byte, abandons the transfer and begins address reception again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (wired-AND value) |
| strap_i | input | 3 | Address straps, compared with bits 3 to 1 of the device byte |
| wp_i | input | 1 | Write protect; high blocks all array updates |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
The hardest situation to reach is the busy window. A poll has to arrive after the stop but before the counter expires, and a second poll has to come after it expires. The bench measures both times from its own stop task and waits a fixed margin beyond BUSY_CYCLES. The second hard situation is a start inside a data byte. The bench clocks half a byte, raises SDA while SCL is low and then issues a start. It then shows through polling and a read-back that the partial byte left no trace.

// File: rtl/see_pkg.sv
package see_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADH,
    ST_ADL,
    ST_WDAT,
    ST_RDAT
  } see_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/see_sync.sv
module see_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/see_bus_events.sv
module see_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic rise,
  output logic fall,
  output logic start,
  output logic stop
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  assign rise  = scl & ~scl_p;
  assign fall  = ~scl & scl_p;
  assign start = scl & scl_p & sda_p & ~sda;
  assign stop  = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import see_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 7,
  parameter int BUSY_CYCLES = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PAGE_SZ = 1 << PAGE_W;
  localparam int ROW_W   = ADDR_W - PAGE_W;
  localparam int HI_W    = ADDR_W - 8;
  localparam int BUSY_W  = $clog2(BUSY_CYCLES + 1);

  // address arithmetic kept in functions so the bench can restate it
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] s);
    return b[7:1] == {DEV_TYPE, s};
  endfunction

  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  function automatic logic [ADDR_W-1:0] lin_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // line synchronizers, one per bus wire
  logic [1:0] raw_l, syn_l;
  assign raw_l = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_sync
    see_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_l[g]), .q(syn_l[g])
    );
  end

  logic scl_s, sda_s;
  assign scl_s = syn_l[1];
  assign sda_s = syn_l[0];

  logic scl_rise, scl_fall, start_ev, stop_ev;
  see_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .rise(scl_rise), .fall(scl_fall), .start(start_ev), .stop(stop_ev)
  );

  see_state_e         state_q, nxt_q, nxt_s;
  logic [3:0]         bitcnt_q;
  logic               in_ack_q, mack_q, dirty_q;
  logic [7:0]         sh_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [HI_W-1:0]    ahi_q;
  logic [PAGE_SZ-1:0] vld_q;
  logic [BUSY_W-1:0]  busy_q;
  logic [7:0]         mem  [DEPTH];
  logic [7:0]         pbuf [PAGE_SZ];

  // named internal events
  logic busy, byte_done, slot_end, ack_now, buf_we, commit_ev;
  logic [ROW_W-1:0] row;
  logic [7:0]       rd_byte;
  see_state_e       slot_tgt;

  assign busy      = busy_q != '0;
  assign byte_done = scl_fall && !in_ack_q && bitcnt_q == 4'd8 &&
                     state_q != ST_IDLE && state_q != ST_RDAT;
  assign slot_end  = scl_fall && in_ack_q;
  assign buf_we    = byte_done && state_q == ST_WDAT && !wp_i;
  assign commit_ev = stop_ev && dirty_q;
  assign row       = addr_q[ADDR_W-1:PAGE_W];
  assign rd_byte   = mem[addr_q];
  assign slot_tgt  = (state_q == ST_RDAT) ? (mack_q ? ST_RDAT : ST_IDLE) : nxt_q;

  always_comb begin
    ack_now = 1'b1;
    nxt_s   = state_q;
    unique case (state_q)
      ST_DEV: begin
        if (busy || !dev_hit(sh_q, strap_i)) begin
          ack_now = 1'b0;
          nxt_s   = ST_IDLE;
        end else begin
          nxt_s = sh_q[0] ? ST_RDAT : ST_ADH;
        end
      end
      ST_ADH:  nxt_s = ST_ADL;
      ST_ADL:  nxt_s = ST_WDAT;
      ST_WDAT: nxt_s = ST_WDAT;
      default: begin
        ack_now = 1'b0;
        nxt_s   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      bitcnt_q <= '0;
      in_ack_q <= 1'b0;
      mack_q   <= 1'b0;
      dirty_q  <= 1'b0;
      sh_q     <= '0;
      addr_q   <= '0;
      ahi_q    <= '0;
      vld_q    <= '0;
      busy_q   <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      if (commit_ev)  busy_q <= BUSY_W'(BUSY_CYCLES);
      else if (busy)  busy_q <= busy_q - BUSY_W'(1);

      if (start_ev || stop_ev) begin
        state_q  <= start_ev ? ST_DEV : ST_IDLE;
        bitcnt_q <= '0;
        in_ack_q <= 1'b0;
        dirty_q  <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (in_ack_q) mack_q <= !sda_s;
          else if (bitcnt_q < 4'd8) begin
            bitcnt_q <= bitcnt_q + 4'd1;
            if (state_q != ST_RDAT) sh_q <= {sh_q[6:0], sda_s};
          end
        end else if (slot_end) begin
          in_ack_q <= 1'b0;
          bitcnt_q <= '0;
          state_q  <= slot_tgt;
          sda_oe_o <= 1'b0;
          if (slot_tgt == ST_RDAT) begin
            sh_q     <= rd_byte;
            sda_oe_o <= ~rd_byte[7];
            addr_q   <= lin_step(addr_q);
          end
        end else if (scl_fall && bitcnt_q == 4'd8) begin
          in_ack_q <= 1'b1;
          if (state_q == ST_RDAT) begin
            sda_oe_o <= 1'b0;
          end else begin
            sda_oe_o <= ack_now;
            nxt_q    <= nxt_s;
            case (state_q)
              ST_ADH: ahi_q <= sh_q[HI_W-1:0];
              ST_ADL: begin
                addr_q <= {ahi_q, sh_q};
                vld_q  <= '0;
              end
              ST_WDAT: begin
                addr_q <= page_step(addr_q);
                if (!wp_i) begin
                  vld_q[addr_q[PAGE_W-1:0]] <= 1'b1;
                  dirty_q <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end else if (scl_fall && state_q == ST_RDAT) begin
          sh_q     <= {sh_q[6:0], 1'b0};
          sda_oe_o <= ~sh_q[6];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[addr_q[PAGE_W-1:0]] <= sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_ev) begin
      for (int i = 0; i < PAGE_SZ; i++)
        if (vld_q[i]) mem[{row, i[PAGE_W-1:0]}] <= pbuf[i];
    end
  end

  // assertions next to the logic they guard
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> ($past(!scl_s) || $past(start_ev || stop_ev))); // R3

  AST_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe_o) && $past(state_q) == ST_DEV && $past(byte_done))
      |-> $past(sh_q[7:1]) == {4'b1010, $past(strap_i)}); // R1

  AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state_q == ST_DEV && busy) |=> !sda_oe_o); // R6

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> busy); // R6

  AST_PAGE_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state_q == ST_WDAT) |=> row == $past(row)); // R5

  AST_WP_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state_q == ST_WDAT && wp_i) |=> (vld_q == $past(vld_q) && dirty_q == $past(dirty_q))); // R7
endmodule

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
  localparam int AW   = 10;
  localparam int BUSY = 3000;
  localparam int Q    = 10;
  localparam logic [7:0] DEV_W = 8'hAA; // 1010_101_0 with straps 101
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  int   n_tests = 0;
  int   n_fail  = 0;
  logic [7:0] model [1 << AW];
  logic [AW-1:0] cur_addr;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  serial_eeprom_slave #(.ADDR_W(AW), .PAGE_W(7), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) i_serial_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(3'b101), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(!mack);
  endtask

  function automatic logic [AW-1:0] in_page(input logic [AW-1:0] base, input int k);
    logic [31:0] t;
    t = 32'(base) + 32'(k);
    return (base & 10'h380) | AW'(t[6:0]);
  endfunction

  task automatic poll(output logic ack);
    bus_start;
    send_byte(DEV_W, ack);
    bus_stop;
  endtask

  task automatic wr_seq(input logic [AW-1:0] a, input int n, input logic [7:0] seed, input string req);
    int nack = 0;
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte(DEV_W, ack);                  if (!ack) nack++;
    send_byte({6'b0, a[9:8]}, ack);         if (!ack) nack++;
    send_byte(a[7:0], ack);                 if (!ack) nack++;
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 3);
      send_byte(d, ack);
      if (!ack) nack++;
      if (!wp) model[in_page(a, k)] = d;
    end
    bus_stop;
    cur_addr = in_page(a, n);
    check(req, nack, 0);
  endtask

  task automatic rd_rand(input logic [AW-1:0] a, input int n, input string req);
    int nack = 0;
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte(DEV_W, ack);          if (!ack) nack++;
    send_byte({6'b0, a[9:8]}, ack); if (!ack) nack++;
    send_byte(a[7:0], ack);         if (!ack) nack++;
    bus_start;
    send_byte(DEV_R, ack);          if (!ack) nack++;
    check(req, nack, 0);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(req, d, model[AW'(a + AW'(k))]);
    end
    bus_stop;
    cur_addr = a + AW'(n);
  endtask

  task automatic rd_cur(input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte(DEV_R, ack);
    check(req, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(req, d, model[AW'(cur_addr + AW'(k))]);
    end
    bus_stop;
    cur_addr = cur_addr + AW'(n);
  endtask

  task automatic wait_busy;
    tick(BUSY + 200);
  endtask

  task automatic t_reset;
    check("R3 idle release", sda_oe, 0);
  endtask

  task automatic t_mismatch;
    logic ack;
    bus_start;
    send_byte(8'hA2, ack);
    check("R2 strap mismatch", ack, 0);
    send_byte(DEV_W, ack);
    check("R2 ignored until start", ack, 0);
    bus_stop;
    bus_start;
    send_byte(8'hB2 | 8'h08, ack);
    check("R1 wrong type bits", ack, 0);
    bus_stop;
    poll(ack);
    check("R1 matching byte", ack, 1);
  endtask

  task automatic t_byte_write;
    logic ack;
    wr_seq(10'h105, 1, 8'hA5, "R4 byte write acks");
    poll(ack);
    check("R6 busy poll", ack, 0);
    wait_busy;
    poll(ack);
    check("R6 ready poll", ack, 1);
    rd_rand(10'h105, 1, "R9");
  endtask

  task automatic t_page_wrap;
    wr_seq(10'h17C, 6, 8'h30, "R4 page acks");
    wait_busy;
    rd_rand(10'h17C, 5, "R5");
    rd_rand(10'h100, 1, "R5");
    rd_cur(2, "R8");
  endtask

  task automatic t_overflow;
    wr_seq(10'h200, 129, 8'h11, "R4 overflow acks");
    wait_busy;
    rd_rand(10'h200, 2, "R5 overwrite");
  endtask

  task automatic t_seq_wrap;
    wr_seq(10'h3FE, 2, 8'hC0, "R4");
    wait_busy;
    wr_seq(10'h000, 2, 8'h50, "R4");
    wait_busy;
    rd_rand(10'h3FE, 4, "R10");
    rd_cur(1, "R8 after wrap");
  endtask

  task automatic t_wp;
    logic ack;
    wp = 1'b1;
    wr_seq(10'h105, 1, 8'h5A, "R7 acks under protect");
    poll(ack);
    check("R7 no busy", ack, 1);
    wp = 1'b0;
    rd_rand(10'h105, 1, "R7 unchanged");
  endtask

  task automatic t_abort;
    logic ack;
    bus_start;
    send_byte(DEV_W, ack);
    send_byte(8'h00, ack);
    send_byte(8'h10, ack);
    bus_stop;
    poll(ack);
    check("R11 header only no busy", ack, 1);
    bus_start;
    send_byte(DEV_W, ack);
    send_byte(8'h00, ack);
    send_byte(8'h20, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start;
    send_byte(DEV_W, ack);
    check("R11 restart mid byte", ack, 1);
    bus_stop;
    poll(ack);
    check("R11 no commit", ack, 1);
    rd_rand(10'h020, 1, "R11 data intact");
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'h00;
    cur_addr = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_mismatch;
    t_byte_write;
    t_page_wrap;
    t_overflow;
    t_seq_wrap;
    t_wp;
    t_abort;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule